// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Divider

This block turns a fast source clock into the serial-clock timing for an SPI shift engine. Everything runs in the source clock domain. The divider does not make a new clock. It makes a one-cycle enable pulse at each half period of the serial clock, plus a registered serial-clock level built from those pulses. The shift engine uses the pulses to launch and capture bits.

Two divider laws are available, and a run-time select bit picks one of them:

- **Binary-exponent law:** total division of 4 × 2^N, set by a 3-bit field.
- **Linear law:** total division of 2 × (N+1), set by an 8-bit field.

Each half period is a whole number of source cycles, so the serial clock always has a 50% duty cycle. While no burst is running, or while the controller is disabled, the serial clock rests at its idle polarity. The divider also restarts from a clean state whenever the selected half period changes, so no period is ever cut short.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `rate_sel` = 0, the half period is 2^(`exp_div`+1) source cycles, so the total division is 2^(`exp_div`+2). This covers 4 for `exp_div` = 0 up to 512 for `exp_div` = 7.
- R2: With `rate_sel` = 1, the half period is `lin_div`+1 source cycles, so the total division is 2×(`lin_div`+1). With `lin_div` = 0, `half_tick` is high on every running cycle.
- R3: The divider field of the path that is not selected has no effect. Changing it during a burst leaves the tick train unchanged.
- R4: `half_tick` is high for exactly one cycle per half period. `period_tick` is high only on every second `half_tick` of a burst (the 2nd, 4th, and so on), which ends each full serial-clock period.
- R5: `sclk` equals `cpol` whenever the divider is not running (`run` = `enable` and `active`). During a burst, `sclk` starts at `cpol` and inverts after each `half_tick`. In the cycle of the m-th tick (counting from 0), `sclk` = `cpol` XOR (m mod 2).
- R6: When the selected half period changes during a burst, no tick occurs in that cycle. The count and the phase restart, and the next tick comes one full new half period later.
- R7: Dropping `enable` stops ticks and forces `sclk` to `cpol`. When `enable` returns, counting restarts from zero with the phase at idle.
- R8: Right after reset with `active` low, there are no ticks and `sclk` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable |
| active | input | 1 | Burst in progress |
| cpol | input | 1 | Idle level of the serial clock |
| exp_div | input | 3 | Exponent N for the binary-exponent path |
| lin_div | input | 8 | Divisor N for the linear path |
| rate_sel | input | 1 | 1 selects the linear path, 0 the binary-exponent path |
| sclk | output | 1 | Serial clock level |
| half_tick | output | 1 | One-cycle pulse at each half period |
| period_tick | output | 1 | One-cycle pulse at the end of each full period |

## Verification
In some cycles a half-period tick and a divider reload fall together. The bench provokes this by switching `rate_sel` in exactly the cycle in which the counter reaches the last count of a half period. It expects that tick to be suppressed, with the train resuming after a full new half period and with `sclk` back at idle level. A second collision is provoked by dropping `enable` one cycle before a tick is due. There the bench expects no tick, the idle level on `sclk`, and a fresh count once `enable` returns. A scoreboard queue holds each expected tick together with its cycle number, its `sclk` level and its `period_tick` value.

// File: rtl/spidiv_pkg.sv
package spidiv_pkg;

  // Half period of the binary-exponent path: 2^(n+1) source cycles.
  function automatic int unsigned exp_half(input int unsigned n);
    return 32'd2 << n;
  endfunction

  // Half period of the linear path: n+1 source cycles.
  function automatic int unsigned lin_half(input int unsigned n);
    return n + 32'd1;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spidiv_rate_sel.sv
module spidiv_rate_sel #(
  parameter int EXP_W = 3,
  parameter int LIN_W = 8,
  parameter int HW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_div,
  input  logic [LIN_W-1:0] lin_div,
  input  logic             rate_sel,
  output logic [HW-1:0]    half_len,
  output logic             cfg_change
);
  import spidiv_pkg::*;

  logic [HW-1:0] exp_len;
  logic [HW-1:0] lin_len;
  logic [HW-1:0] half_q;

  always_comb begin
    exp_len  = HW'(exp_half(32'(exp_div)));
    lin_len  = HW'(lin_half(32'(lin_div)));
    half_len = rate_sel ? lin_len : exp_len;
  end

  // Remember the half period in use; any difference forces a reload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= '0;
    else        half_q <= half_len;
  end

  assign cfg_change = (half_len != half_q);

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    half_len != '0);

endmodule

// File: rtl/spidiv_counter.sv
module spidiv_counter #(
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          reload,
  input  logic [HW-1:0] half_len,
  output logic          half_tick
);
  logic [HW-1:0] cnt_q;
  logic          at_end;

  assign at_end    = (cnt_q == half_len - HW'(1));
  assign half_tick = run && !reload && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (!run || reload || half_tick) cnt_q <= '0;
    else                                cnt_q <= cnt_q + HW'(1);
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !reload) |-> (cnt_q < half_len));

  assert_reload_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == '0));

  assert_start_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/spidiv_phase.sv
module spidiv_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic reload,
  input  logic half_tick,
  input  logic cpol,
  output logic sclk,
  output logic period_tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= 1'b0;
    else if (!run || reload) phase_q <= 1'b0;
    else if (half_tick)      phase_q <= ~phase_q;
  end

  assign sclk        = run ? (cpol ^ phase_q) : cpol;
  assign period_tick = half_tick && phase_q;

  assert_sclk_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(half_tick) && run && $stable(cpol)) |-> (sclk != $past(sclk)));

  assert_sclk_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(half_tick) && !$past(reload) && $stable(cpol))
      |-> $stable(sclk));

  assert_period_active_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> (sclk != cpol));

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int EXP_W = 3,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             active,
  input  logic             cpol,
  input  logic [EXP_W-1:0] exp_div,
  input  logic [LIN_W-1:0] lin_div,
  input  logic             rate_sel,
  output logic             sclk,
  output logic             half_tick,
  output logic             period_tick
);
  import spidiv_pkg::*;

  localparam int unsigned EXP_MAX = exp_half((32'd1 << EXP_W) - 32'd1);
  localparam int unsigned LIN_MAX = lin_half((32'd1 << LIN_W) - 32'd1);
  localparam int          HW      = $clog2(max_u(EXP_MAX, LIN_MAX)) + 1;

  logic          run;
  logic          reload;
  logic [HW-1:0] half_len;

  assign run = enable && active;

  spidiv_rate_sel #(.EXP_W(EXP_W), .LIN_W(LIN_W), .HW(HW)) u_sel (
    .clk(clk), .rst_n(rst_n), .exp_div(exp_div), .lin_div(lin_div),
    .rate_sel(rate_sel), .half_len(half_len), .cfg_change(reload)
  );

  spidiv_counter #(.HW(HW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
    .half_len(half_len), .half_tick(half_tick)
  );

  spidiv_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
    .half_tick(half_tick), .cpol(cpol), .sclk(sclk), .period_tick(period_tick)
  );

  assert_no_tick_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!half_tick && sclk == cpol));

endmodule

// File: tb/spi_sclk_divider_bench.sv
module spi_sclk_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       active = 1'b0;
  logic       cpol = 1'b1;
  logic [2:0] exp_div = '0;
  logic [7:0] lin_div = '0;
  logic       rate_sel = 1'b0;
  logic       sclk, half_tick, period_tick;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int cyc; bit sclk; bit per; string req; } exp_t;
  exp_t q[$];

  spi_sclk_divider u_spi_sclk_divider (
    .clk(clk), .rst_n(rst_n), .enable(enable), .active(active), .cpol(cpol),
    .exp_div(exp_div), .lin_div(lin_div), .rate_sel(rate_sel),
    .sclk(sclk), .half_tick(half_tick), .period_tick(period_tick)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Expected half period written from the division laws.
  function automatic int half_of(input bit sel, input int en, input int ln);
    return sel ? (ln + 1) : ((4 * (1 << en)) / 2);
  endfunction

  task automatic push_run(input int start, input int h, input int n, input bit pol, input string req);
    for (int m = 0; m < n; m++) begin
      exp_t e;
      e.cyc = start + h - 1 + m * h;
      e.sclk = pol ^ m[0];
      e.per = m[0];
      e.req = req;
      q.push_back(e);
    end
  endtask

  // Monitor: compares every observed tick with the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && half_tick) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected tick", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.cyc, {e.req, " tick cycle"}, cyc, e.cyc);
          check(sclk == e.sclk, {e.req, " R5 sclk at tick"}, sclk, e.sclk);
          check(period_tick == e.per, {e.req, " R4 period_tick"}, period_tick, e.per);
        end
      end else if (rst_n && period_tick) begin
        check(1'b0, "R4 period_tick without half_tick", 1, 0);
      end
    end
  end

  task automatic setup(input bit sel, input int en, input int ln, input bit pol);
    @(negedge clk);
    rate_sel = sel; exp_div = 3'(en); lin_div = 8'(ln); cpol = pol;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_burst(input bit pol, input string req);
    active = 1'b0;
    #2;
    check(sclk == pol, {req, " R5 idle level after burst"}, sclk, pol);
    check(q.size() == 0, {req, " missing ticks"}, q.size(), 0);
  endtask

  task automatic burst(input bit sel, input int en, input int ln, input bit pol, input int n, input string req);
    int h, c0;
    h = half_of(sel, en, ln);
    setup(sel, en, ln, pol);
    active = 1'b1;
    c0 = cyc;
    push_run(c0, h, n, pol, req);
    repeat (n * h) @(negedge clk);
    finish_burst(pol, req);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    #2;
    check(sclk == 1'b1, "R8 sclk at cpol in reset", sclk, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(sclk == 1'b1 && half_tick == 1'b0, "R8 idle after reset", {sclk, half_tick}, 2);

    burst(1'b0, 0, 9, 1'b0, 5, "R1 exp N=0");
    burst(1'b0, 2, 9, 1'b1, 4, "R1 exp N=2");
    burst(1'b0, 7, 9, 1'b0, 2, "R1 exp N=7");
    burst(1'b1, 3, 0, 1'b0, 6, "R2 lin N=0");
    burst(1'b1, 3, 2, 1'b1, 4, "R2 lin N=2");
    burst(1'b1, 3, 255, 1'b0, 2, "R2 lin N=255");

    // R3: the unselected linear field changes mid-burst.
    setup(1'b0, 0, 5, 1'b0);
    active = 1'b1; c0 = cyc;
    push_run(c0, 2, 6, 1'b0, "R3 ignored field");
    repeat (3) @(negedge clk);
    lin_div = 8'd77;
    repeat (9) @(negedge clk);
    finish_burst(1'b0, "R3");

    // R6: path switch lands exactly on a due tick.
    setup(1'b0, 1, 2, 1'b1);
    active = 1'b1; c0 = cyc;
    push_run(c0 + 4, 3, 3, 1'b1, "R6 reload");
    repeat (3) @(negedge clk);
    rate_sel = 1'b1;
    #2;
    check(half_tick == 1'b0, "R6 tick suppressed on change", half_tick, 0);
    repeat (10) @(negedge clk);
    finish_burst(1'b1, "R6");

    // R7: enable drops one cycle before a tick.
    setup(1'b1, 0, 2, 1'b0);
    active = 1'b1; c0 = cyc;
    push_run(c0, 3, 1, 1'b0, "R7 before disable");
    repeat (4) @(negedge clk);
    enable = 1'b0;
    #2;
    check(sclk == 1'b0 && half_tick == 1'b0, "R7 disabled idle", {sclk, half_tick}, 0);
    @(negedge clk);
    enable = 1'b1;
    push_run(c0 + 5, 3, 3, 1'b0, "R7 restart");
    repeat (9) @(negedge clk);
    finish_burst(1'b0, "R7");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule